// File: doc/BRIEF.md
# FIFO-fed lookup table loader

The loader takes correction words from a host-fed FIFO and writes them into an on-chip lookup table. Processing logic keeps reading the table through its own read port while the load runs. A load starts on a rising edge of the update control. It stops by itself once a programmed number of words has been accepted, so no stop control is needed.

There are two load modes. In sequential mode, each FIFO word carries one 16-bit signed table entry in its low half. The entries go to consecutive addresses, beginning at a programmable start address. Because the load can begin anywhere, a partial reload rewrites only a slice of the table. In packed mode, each 32-bit FIFO word carries its own target address in the upper half and the entry in the lower half, which suits scattered corrections. Each word is popped and written in the same clock cycle, with no stall cycle.

Top module: `lut_loader`

## Requirements
- R1: A table write happens only in a cycle where `fifo_valid_i` and `fifo_pop_o` are both high. A cycle without valid data writes nothing and does not advance the address or the word count.
- R2: In sequential mode (`packed_mode_i`=0), the first accepted word goes to `start_addr_i`. Each further accepted word goes to the previous address plus one. The entry is `fifo_data_i[15:0]`.
- R3: In packed mode (`packed_mode_i`=1), the target address is the low `ADDR_W` bits of `fifo_data_i[31:16]`, and the entry is `fifo_data_i[15:0]`. The sequential address counter does not move.
- R4: A load starts when `update_i` is high in the current cycle and was low in the previous cycle. Holding `update_i` high starts nothing further. `busy_o` rises one cycle after the edge cycle, and `fifo_pop_o` is low in the edge cycle itself.
- R5: Once `load_len_i` words have been accepted, `busy_o` and `fifo_pop_o` fall. Words offered after that are not written.
- R6: `done_o` is high for exactly one cycle: the cycle after the clock edge that writes the final word. `busy_o` is low in that cycle. `fifo_pop_o` equals `busy_o` except in an update edge cycle.
- R7: An update edge during a load aborts it. The next load restarts at the current `start_addr_i` with the word count cleared.
- R8: `rd_data_o` shows the entry at `rd_addr_i` one clock after the address is presented. A write to the same address in that same cycle returns the old entry.
- R9: Reset clears `busy_o`, `done_o` and the update edge history, and leaves the table contents unchanged.
- R10: An update edge with `load_len_i`=0 writes nothing, keeps `busy_o` low, and pulses `done_o` in the next cycle.
- R11: The sequential address wraps from the last table entry to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| packed_mode_i | input | 1 | 0 = sequential, 1 = packed address:data |
| update_i | input | 1 | Load request, rising edge starts or restarts |
| start_addr_i | input | ADDR_W | First address of a sequential load |
| load_len_i | input | ADDR_W+1 | Words in one load |
| fifo_data_i | input | 32 | FIFO read data |
| fifo_valid_i | input | 1 | FIFO read data valid |
| fifo_pop_o | output | 1 | FIFO pop, word taken when valid is also high |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| rd_addr_i | input | ADDR_W | Lookup read address |
| rd_data_o | output | 16 | Lookup read data, one-cycle latency |

## Verification
A wrong address counter does not show at the write itself. It shows as misplaced entries, found only when the table is read back, which takes one read cycle per entry after the load. A wrong word count shows earlier, at the end of the load: `busy_o`, `fifo_pop_o` and `done_o` move on the wrong cycle. A stale edge history shows as a missing or extra start in the cycle after the update edge. The bench compares all three handshake outputs every cycle, and it reads back every known entry after each scenario.

// File: rtl/lut_loader_pkg.sv
package lut_loader_pkg;
  localparam int unsigned ENTRY_W = 16;
  localparam int unsigned WORD_W  = 2 * ENTRY_W;

  typedef enum logic {
    LD_SEQ    = 1'b0,
    LD_PACKED = 1'b1
  } ld_mode_e;
endpackage

// File: rtl/lut_edge_det.sv
module lut_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
    rise_o = level_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/lut_load_ctrl.sv
module lut_load_ctrl
  import lut_loader_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  ld_mode_e          mode_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ENTRY_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [LEN_W-1:0]  cnt_o
);
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  cnt_q,  cnt_d;
  logic [LEN_W-1:0]  cnt_inc;
  logic              accept;

  always_comb begin
    pop_o   = busy_q & ~start_i;
    accept  = pop_o & valid_i;
    cnt_inc = cnt_q + 1'b1;
    busy_d  = busy_q;
    done_d  = 1'b0;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      addr_d = start_addr_i;
      cnt_d  = '0;
      if (len_i == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
      end
    end else if (accept) begin
      cnt_d = cnt_inc;
      if (mode_i == LD_SEQ) addr_d = addr_q + 1'b1;
      if (cnt_inc == len_i) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        addr_d = start_addr_i;
      end
    end
  end

  always_comb begin
    we_o    = accept;
    wdata_o = word_i[ENTRY_W-1:0];
    if (mode_i == LD_PACKED) waddr_o = word_i[ENTRY_W +: ADDR_W];
    else                     waddr_o = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign seq_addr_o = addr_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/lut_dpram.sv
module lut_dpram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lut_loader.sv
module lut_loader
  import lut_loader_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned LEN_W = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               packed_mode_i,
  input  logic               update_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic [LEN_W-1:0]   load_len_i,
  input  logic [WORD_W-1:0]  fifo_data_i,
  input  logic               fifo_valid_i,
  output logic               fifo_pop_o,
  output logic               busy_o,
  output logic               done_o,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  logic               upd_rise;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [ENTRY_W-1:0] wr_data;
  logic [ADDR_W-1:0]  seq_addr;
  logic [LEN_W-1:0]   word_cnt;
  ld_mode_e           mode;

  assign mode = packed_mode_i ? LD_PACKED : LD_SEQ;

  lut_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(update_i),
    .rise_o (upd_rise)
  );

  lut_load_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (upd_rise),
    .mode_i      (mode),
    .start_addr_i(start_addr_i),
    .len_i       (load_len_i),
    .word_i      (fifo_data_i),
    .valid_i     (fifo_valid_i),
    .pop_o       (fifo_pop_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .we_o        (wr_en),
    .waddr_o     (wr_addr),
    .wdata_o     (wr_data),
    .seq_addr_o  (seq_addr),
    .cnt_o       (word_cnt)
  );

  lut_dpram #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) u_mem (
    .clk    (clk),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/lut_loader_chk.sv
module lut_loader_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              update_i,
  input logic              packed_mode_i,
  input logic              fifo_valid_i,
  input logic              fifo_pop_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              upd_rise,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [LEN_W-1:0]  word_cnt
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R5
  pop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> busy_o);

  // R4
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && !$past(update_i)) |=> (busy_o || done_o));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fifo_valid_i && !upd_rise) |=>
      (word_cnt == $past(word_cnt) && seq_addr == $past(seq_addr)));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid_i && fifo_pop_o && !packed_mode_i) |=>
      (done_o || seq_addr == ADDR_W'($past(seq_addr) + 1'b1)));
endmodule

bind lut_loader lut_loader_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .update_i     (update_i),
  .packed_mode_i(packed_mode_i),
  .fifo_valid_i (fifo_valid_i),
  .fifo_pop_o   (fifo_pop_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .upd_rise     (upd_rise),
  .seq_addr     (seq_addr),
  .word_cnt     (word_cnt)
);

// File: tb/lut_loader_tb.sv
module lut_loader_tb;
  localparam int AW    = 8;
  localparam int LW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          packed_mode;
  logic          update;
  logic [AW-1:0] start_addr;
  logic [LW-1:0] load_len;
  logic [31:0]   fifo_data;
  logic          fifo_valid;
  logic          fifo_pop;
  logic          busy;
  logic          done;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit          m_busy, m_done, m_prev;
  int          m_cnt;
  logic [AW-1:0] m_addr;
  logic [15:0] mem_m [DEPTH];
  bit          known [DEPTH];
  bit          track_rd = 0;

  always #5 clk = ~clk;

  lut_loader #(.ADDR_W(AW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .packed_mode_i(packed_mode),
    .update_i     (update),
    .start_addr_i (start_addr),
    .load_len_i   (load_len),
    .fifo_data_i  (fifo_data),
    .fifo_valid_i (fifo_valid),
    .fifo_pop_o   (fifo_pop),
    .busy_o       (busy),
    .done_o       (done),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_edge();
    return update && !m_prev;
  endfunction

  // one clock: inputs already driven; checks pop now, busy/done/rd after the edge
  task automatic step(input string tag);
    bit          rise, exp_pop, rd_known;
    logic [15:0] exp_rd;
    logic [AW-1:0] wa;
    if (track_rd) rd_addr = m_addr;
    #1;
    rise    = model_edge();
    exp_pop = m_busy && !rise;
    chk(fifo_pop === exp_pop, tag, "pop", fifo_pop, exp_pop);
    rd_known = known[rd_addr];
    exp_rd   = mem_m[rd_addr];
    m_prev = update;
    m_done = 0;
    if (rise) begin
      m_addr = start_addr;
      m_cnt  = 0;
      if (load_len == 0) begin m_busy = 0; m_done = 1; end
      else m_busy = 1;
    end else if (exp_pop && fifo_valid) begin
      wa = packed_mode ? fifo_data[16 +: AW] : m_addr;
      mem_m[wa] = fifo_data[15:0];
      known[wa] = 1;
      m_cnt++;
      if (!packed_mode) m_addr = m_addr + 1'b1;
      if (m_cnt == int'(load_len)) begin
        m_busy = 0; m_done = 1; m_addr = start_addr;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(busy === m_busy, tag, "busy", busy, m_busy);
    chk(done === m_done, tag, "done", done, m_done);
    if (rd_known) chk(rd_data === exp_rd, tag, "rd_data", rd_data, exp_rd);
  endtask

  task automatic idle_inputs();
    fifo_valid = 0;
    fifo_data  = '0;
  endtask

  // start a load, feed words until it ends, then offer extra words (R5)
  task automatic run_load(input bit pmode, input int start, input int len,
                          input int vpct, input string tag);
    idle_inputs();
    packed_mode = pmode;
    start_addr  = AW'(start);
    load_len    = LW'(len);
    update = 0; step(tag);
    update = 1; step("R4");
    while (m_busy) begin
      fifo_valid = ($urandom % 100) < vpct;
      fifo_data  = $urandom;
      step(tag);
    end
    for (int i = 0; i < 4; i++) begin
      fifo_valid = 1; fifo_data = $urandom;
      step("R5");
    end
    idle_inputs();
    update = 0; step(tag);
  endtask

  task automatic scan(input string tag);
    idle_inputs();
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      step(tag);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 0;
    #1;
    m_busy = 0; m_done = 0; m_prev = 0; m_cnt = 0; m_addr = '0;
    chk(busy === 1'b0, tag, "busy in reset", busy, 0);
    chk(done === 1'b0, tag, "done in reset", done, 0);
    chk(fifo_pop === 1'b0, tag, "pop in reset", fifo_pop, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    rst_n = 0; packed_mode = 0; update = 0; start_addr = '0;
    load_len = '0; rd_addr = '0; idle_inputs();
    m_busy = 0; m_done = 0; m_prev = 0; m_cnt = 0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(busy === 1'b0 && done === 1'b0 && fifo_pop === 1'b0, "R9", "reset state",
        {busy, done, fifo_pop}, 0);

    // R1 R2: full sequential load with gaps in valid
    run_load(0, 0, DEPTH, 60, "R1");
    scan("R2");

    // R11: partial reload that wraps past the last entry
    run_load(0, DEPTH - 6, 12, 80, "R11");
    scan("R11");

    // R3: scattered packed writes
    run_load(1, 17, 24, 75, "R3");
    scan("R3");

    // R10: zero-length load
    run_load(0, 5, 0, 100, "R10");

    // R8: read address follows write address during a load
    track_rd = 1;
    run_load(0, 40, 30, 100, "R8");
    track_rd = 0;

    // R7: abort after a few words, restart elsewhere
    idle_inputs(); packed_mode = 0; start_addr = AW'(100); load_len = LW'(20);
    update = 0; step("R7");
    update = 1; step("R7");
    for (int i = 0; i < 5; i++) begin
      fifo_valid = 1; fifo_data = $urandom; step("R7");
    end
    update = 0; fifo_valid = 0; step("R7");
    start_addr = AW'(200); update = 1; fifo_valid = 1; step("R7");
    while (m_busy) begin
      fifo_valid = 1; fifo_data = $urandom; step("R7");
    end
    idle_inputs(); update = 0; step("R7");
    scan("R7");

    // R9: reset in the middle of a load keeps the table
    idle_inputs(); start_addr = AW'(60); load_len = LW'(50);
    update = 0; step("R9");
    update = 1; step("R9");
    for (int i = 0; i < 7; i++) begin
      fifo_valid = 1; fifo_data = $urandom; step("R9");
    end
    idle_inputs(); update = 0;
    do_reset("R9");
    step("R9");
    scan("R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 30 == 0) update = ~update;
      if (!m_busy) begin
        packed_mode = $urandom % 3 == 0;
        start_addr  = $urandom;
        load_len    = LW'($urandom % 40);
      end
      fifo_valid = ($urandom % 100) < 70;
      fifo_data  = $urandom;
      rd_addr    = $urandom;
      step("R6");
    end
    idle_inputs(); update = 0; step("R6");
    scan("R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule